// File: doc/BRIEF.md
# ADC Cross-Trigger Conversion Sequencer

This block orders conversion requests for a successive-approximation ADC and times each conversion. Software can ask for a normal or an injected conversion on a chosen channel. An external cross-triggering unit can also fire one-cycle trigger pulses, each with a channel number. Every accepted request converts exactly one channel. The conversion runs through three phases: sampling, then bit evaluation, then a latch phase. Each phase length comes from a programmed count of ADC clock periods. The ADC clock is `clk_i` divided by two, so all phase lengths below are given in `clk_i` cycles.

The analog converter sits outside the block. Its output is presented on `adc_result_i` and is captured when evaluation ends. Each finished result is stored in the data register for its channel, and it is also sent out as a one-cycle result beat tagged with the channel number. The result is then checked against that channel's low and high watchdog thresholds.

When `xtrig_en_i` is high, the block is in trigger-control mode. Software requests are dropped in this mode. A trigger that arrives while the block is busy waits in a single pending slot. Two sticky flags report mode activity: a trigger-started flag, and an overrun flag that is set when a trigger finds the pending slot already full.

Top module: `adc_xtrig_seq`

## Requirements
- R1: Normal mode, block idle: a software request starts one conversion on its channel. If `sw_inj_req_i` and `sw_norm_req_i` arrive in the same cycle, the injected one wins and uses `sw_inj_ch_i`. Software requests made while busy are dropped. Trigger pulses have no effect in normal mode.
- R2: With `xtrig_en_i`=1, software requests are dropped, so `busy_o` stays 0 after them. Only trigger pulses start conversions in this mode.
- R3: In trigger-control mode, a one-cycle `xtrig_pulse_i` received while idle starts a conversion on `xtrig_ch_i`. That conversion produces exactly one result.
- R4: `xtrig_started_o` goes to 1 when a trigger-started conversion begins. It stays 1 until `xtrig_en_i` is 0, and clearing the enable clears it.
- R5: A trigger that arrives while busy is held in one pending slot and is converted when the current conversion ends. A further trigger that finds the slot full sets `overrun_o` and is discarded. `overrun_o` clears only when `xtrig_en_i` is 0.
- R6: `sample_o` is high for 2*`samp_cnt_i`-1 cycles when `samp_cnt_i` <= 6, and for 2*`samp_cnt_i`-2 cycles when `samp_cnt_i` > 6. In ADC periods this is (samp - 0.5) or (samp - 1). `samp_cnt_i` must be at least 3.
- R7: Call the accept edge cycle 0. `res_valid_o` is high exactly sample_len + 20*`cmp_cnt_i` + 2*`latch_cnt_i` cycles later. The factor 20 is 10 result bits times 2 clk cycles per ADC period. `adc_result_i` is captured in the last evaluation cycle.
- R8: `res_valid_o` is high for one cycle, with `res_ch_o` and `res_data_o` showing the channel and the result. In the same cycle the data register of that channel is updated. It can be read combinationally through `rd_ch_i`/`rd_data_o`.
- R9: A channel's watchdog flag (`wdg_flag_o` bit = channel index) is set when that channel's `wdg_en_i` bit is 1 and the result is strictly below its low threshold or strictly above its high threshold. A result equal to either threshold does not set it. The flag is never set when watchdog checking is disabled for the channel.
- R10: Writing 1 to a `wdg_clr_i` bit clears only that channel's flag. A set in the same cycle wins over the clear.
- R11: After reset, every output is 0 and every data register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the ADC clock is clk_i/2 |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xtrig_en_i | input | 1 | Trigger-control mode enable |
| sw_norm_req_i | input | 1 | Software normal conversion request |
| sw_norm_ch_i | input | CH_W | Channel for the normal request |
| sw_inj_req_i | input | 1 | Software injected conversion request |
| sw_inj_ch_i | input | CH_W | Channel for the injected request |
| xtrig_pulse_i | input | 1 | One-cycle trigger pulse |
| xtrig_ch_i | input | CH_W | Channel carried with the trigger |
| samp_cnt_i | input | CNT_W | Sample count in ADC periods (>= 3) |
| cmp_cnt_i | input | CNT_W | Evaluation ADC periods per bit (>= 1) |
| latch_cnt_i | input | CNT_W | Latch ADC periods (>= 1) |
| adc_result_i | input | RES_W | Converter output |
| wdg_en_i | input | NUM_CH | Per-channel watchdog enable |
| thr_lo_i | input | NUM_CH*RES_W | Packed low thresholds |
| thr_hi_i | input | NUM_CH*RES_W | Packed high thresholds |
| wdg_clr_i | input | NUM_CH | Write-1-to-clear watchdog flags |
| rd_ch_i | input | CH_W | Data register read select |
| rd_data_o | output | RES_W | Selected data register |
| busy_o | output | 1 | Conversion in progress |
| sample_o | output | 1 | Sampling phase active |
| res_valid_o | output | 1 | Result beat |
| res_ch_o | output | CH_W | Result channel |
| res_data_o | output | RES_W | Result value |
| wdg_flag_o | output | NUM_CH | Watchdog flags |
| xtrig_started_o | output | 1 | Sticky trigger-started status |
| overrun_o | output | 1 | Sticky pending-slot overrun |

## Verification
The assertions assume that the timing counts and thresholds only change while `busy_o` is low. They also assume that `samp_cnt_i` is at least 3 and the other two counts are at least 1. Finally, they assume every trigger pulse is exactly one cycle wide. The stimulus only reprograms counts between conversions, after the result beat. It sweeps `samp_cnt_i` from 3 to 8, with both 1 and 2 for the other counts. Every request and trigger pulse is held for a single cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SAMP, PH_EVAL, PH_LATCH} phase_e;
  localparam int unsigned HALF_SAMP_MAX = 6;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] samp_cnt_i,
  input  logic [CNT_W-1:0] cmp_cnt_i,
  input  logic [CNT_W-1:0] latch_cnt_i,
  output phase_e           phase_o,
  output logic             capture_o,
  output logic             done_o
);
  localparam int unsigned EVAL_MUL = 2 * RES_W;
  localparam int unsigned LEN_W    = CNT_W + $clog2(EVAL_MUL) + 1;

  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] samp_len, eval_len, latch_len, samp2;

  // half-period offset: sampling opens on the falling ADC-clock edge when samp <= 6
  assign samp2     = LEN_W'({samp_cnt_i, 1'b0});
  assign samp_len  = (samp_cnt_i <= CNT_W'(HALF_SAMP_MAX)) ? samp2 - LEN_W'(1) : samp2 - LEN_W'(2);
  assign eval_len  = LEN_W'(cmp_cnt_i) * LEN_W'(EVAL_MUL);
  assign latch_len = LEN_W'({latch_cnt_i, 1'b0});

  assign capture_o = (phase_q == PH_EVAL) && (cnt_q == '0);
  assign done_o    = (phase_q == PH_LATCH) && (cnt_q == '0);
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SAMP;
          cnt_q   <= samp_len - LEN_W'(1);
        end
        PH_SAMP: if (cnt_q == '0) begin
          phase_q <= PH_EVAL;
          cnt_q   <= eval_len - LEN_W'(1);
        end else cnt_q <= cnt_q - LEN_W'(1);
        PH_EVAL: if (cnt_q == '0) begin
          phase_q <= PH_LATCH;
          cnt_q   <= latch_len - LEN_W'(1);
        end else cnt_q <= cnt_q - LEN_W'(1);
        PH_LATCH: if (cnt_q == '0) begin
          if (start_i) begin
            phase_q <= PH_SAMP;
            cnt_q   <= samp_len - LEN_W'(1);
          end else phase_q <= PH_IDLE;
        end else cnt_q <= cnt_q - LEN_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_idle_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !start_i) |=> (phase_q == PH_IDLE));
  assert_samp_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SAMP) |-> (cnt_q < samp_len));
  assert_eval_after_samp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SAMP) |=> (phase_q inside {PH_SAMP, PH_EVAL}));
endmodule

// File: rtl/adc_seq_arb.sv
module adc_seq_arb #(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xtrig_en_i,
  input  logic            sw_norm_req_i,
  input  logic [CH_W-1:0] sw_norm_ch_i,
  input  logic            sw_inj_req_i,
  input  logic [CH_W-1:0] sw_inj_ch_i,
  input  logic            xtrig_pulse_i,
  input  logic [CH_W-1:0] xtrig_ch_i,
  input  logic            idle_i,
  input  logic            done_i,
  output logic            start_o,
  output logic [CH_W-1:0] start_ch_o,
  output logic            started_o,
  output logic            overrun_o
);
  logic            pend_vld_q, started_q, overrun_q;
  logic [CH_W-1:0] pend_ch_q;
  logic            trig, from_pend, from_trig;

  assign trig      = xtrig_en_i && xtrig_pulse_i;
  assign from_pend = xtrig_en_i && pend_vld_q && (idle_i || done_i);
  assign from_trig = trig && idle_i && !pend_vld_q;

  always_comb begin
    start_o    = 1'b0;
    start_ch_o = '0;
    if (xtrig_en_i) begin
      if (from_pend) begin
        start_o = 1'b1; start_ch_o = pend_ch_q;
      end else if (from_trig) begin
        start_o = 1'b1; start_ch_o = xtrig_ch_i;
      end
    end else if (idle_i) begin
      if (sw_inj_req_i) begin
        start_o = 1'b1; start_ch_o = sw_inj_ch_i;
      end else if (sw_norm_req_i) begin
        start_o = 1'b1; start_ch_o = sw_norm_ch_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_ch_q  <= '0;
      started_q  <= 1'b0;
      overrun_q  <= 1'b0;
    end else if (!xtrig_en_i) begin
      pend_vld_q <= 1'b0;
      started_q  <= 1'b0;
      overrun_q  <= 1'b0;
    end else begin
      if (start_o) started_q <= 1'b1;
      if (trig && !from_trig) begin
        if (pend_vld_q && !from_pend) overrun_q <= 1'b1;
        else begin
          pend_vld_q <= 1'b1;
          pend_ch_q  <= xtrig_ch_i;
        end
      end else if (from_pend) pend_vld_q <= 1'b0;
    end
  end

  assign started_o = started_q;
  assign overrun_o = overrun_q;

  assert_ctrl_blocks_sw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xtrig_en_i && !xtrig_pulse_i && !pend_vld_q) |-> !start_o);
  assert_started_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xtrig_en_i && started_q) |=> (started_q || !xtrig_en_i));
  assert_overrun_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xtrig_en_i && overrun_q) |=> (overrun_q || !xtrig_en_i));
  assert_pend_only_ctrl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xtrig_en_i |=> !pend_vld_q);
endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned RES_W  = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic [RES_W-1:0]        wr_data_i,
  input  logic [NUM_CH-1:0]       wdg_en_i,
  input  logic [NUM_CH*RES_W-1:0] thr_lo_i,
  input  logic [NUM_CH*RES_W-1:0] thr_hi_i,
  input  logic [NUM_CH-1:0]       wdg_clr_i,
  input  logic [CH_W-1:0]         rd_ch_i,
  output logic [RES_W-1:0]        rd_data_o,
  output logic [NUM_CH-1:0]       wdg_flag_o
);
  logic [RES_W-1:0]  data_q [NUM_CH];
  logic [NUM_CH-1:0] flag_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             sel, hit;
    logic [RES_W-1:0] lo, hi;
    assign lo  = thr_lo_i[c*RES_W +: RES_W];
    assign hi  = thr_hi_i[c*RES_W +: RES_W];
    assign sel = wr_i && (wr_ch_i == CH_W'(c));
    assign hit = sel && wdg_en_i[c] && ((wr_data_i < lo) || (wr_data_i > hi));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[c] <= '0;
        flag_q[c] <= 1'b0;
      end else begin
        if (sel) data_q[c] <= wr_data_i;
        if (hit) flag_q[c] <= 1'b1;
        else if (wdg_clr_i[c]) flag_q[c] <= 1'b0;
      end
    end

    assert_flag_needs_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q[c] && !sel) |=> !flag_q[c]);
    assert_flag_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q[c] && !wdg_en_i[c]) |=> !flag_q[c]);
  end

  assign rd_data_o  = data_q[rd_ch_i];
  assign wdg_flag_o = flag_q;
endmodule

// File: rtl/adc_xtrig_seq.sv
module adc_xtrig_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned CNT_W  = 5,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    xtrig_en_i,
  input  logic                    sw_norm_req_i,
  input  logic [CH_W-1:0]         sw_norm_ch_i,
  input  logic                    sw_inj_req_i,
  input  logic [CH_W-1:0]         sw_inj_ch_i,
  input  logic                    xtrig_pulse_i,
  input  logic [CH_W-1:0]         xtrig_ch_i,
  input  logic [CNT_W-1:0]        samp_cnt_i,
  input  logic [CNT_W-1:0]        cmp_cnt_i,
  input  logic [CNT_W-1:0]        latch_cnt_i,
  input  logic [RES_W-1:0]        adc_result_i,
  input  logic [NUM_CH-1:0]       wdg_en_i,
  input  logic [NUM_CH*RES_W-1:0] thr_lo_i,
  input  logic [NUM_CH*RES_W-1:0] thr_hi_i,
  input  logic [NUM_CH-1:0]       wdg_clr_i,
  input  logic [CH_W-1:0]         rd_ch_i,
  output logic [RES_W-1:0]        rd_data_o,
  output logic                    busy_o,
  output logic                    sample_o,
  output logic                    res_valid_o,
  output logic [CH_W-1:0]         res_ch_o,
  output logic [RES_W-1:0]        res_data_o,
  output logic [NUM_CH-1:0]       wdg_flag_o,
  output logic                    xtrig_started_o,
  output logic                    overrun_o
);
  phase_e           phase;
  logic             start, capture, done;
  logic [CH_W-1:0]  start_ch, cur_ch_q;
  logic [RES_W-1:0] res_q;

  adc_seq_arb #(.CH_W(CH_W)) u_arb (
    .clk_i, .rst_ni, .xtrig_en_i,
    .sw_norm_req_i, .sw_norm_ch_i, .sw_inj_req_i, .sw_inj_ch_i,
    .xtrig_pulse_i, .xtrig_ch_i,
    .idle_i     (phase == PH_IDLE),
    .done_i     (done),
    .start_o    (start),
    .start_ch_o (start_ch),
    .started_o  (xtrig_started_o),
    .overrun_o  (overrun_o)
  );

  adc_seq_timer #(.CNT_W(CNT_W), .RES_W(RES_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i   (start),
    .samp_cnt_i, .cmp_cnt_i, .latch_cnt_i,
    .phase_o   (phase),
    .capture_o (capture),
    .done_o    (done)
  );

  adc_seq_store #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W)) u_store (
    .clk_i, .rst_ni,
    .wr_i      (done),
    .wr_ch_i   (cur_ch_q),
    .wr_data_i (res_q),
    .wdg_en_i, .thr_lo_i, .thr_hi_i, .wdg_clr_i, .rd_ch_i,
    .rd_data_o, .wdg_flag_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_ch_q    <= '0;
      res_q       <= '0;
      res_valid_o <= 1'b0;
      res_ch_o    <= '0;
      res_data_o  <= '0;
    end else begin
      if (start)   cur_ch_q <= start_ch;
      if (capture) res_q    <= adc_result_i;
      res_valid_o <= done;
      if (done) begin
        res_ch_o   <= cur_ch_q;
        res_data_o <= res_q;
      end
    end
  end

  assign busy_o   = (phase != PH_IDLE);
  assign sample_o = (phase == PH_SAMP);

  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  assert_valid_after_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(busy_o));
  assert_sample_from_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o) |-> $past(start));
endmodule

// File: tb/adc_xtrig_seq_bench.sv
module adc_xtrig_seq_bench;
  localparam int NUM_CH = 4;
  localparam int RES_W  = 10;
  localparam int CNT_W  = 5;
  localparam int CH_W   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic xtrig_en = 0, sw_norm = 0, sw_inj = 0, xtrig = 0;
  logic [CH_W-1:0] norm_ch = 0, inj_ch = 0, xch = 0, rd_ch = 0;
  logic [CNT_W-1:0] samp = 5'd3, cmp = 5'd1, lat = 5'd1;
  logic [RES_W-1:0] adc_res = 0;
  logic [NUM_CH-1:0] wdg_en = 4'b0101, wdg_clr = 0;
  logic [NUM_CH*RES_W-1:0] thr_lo, thr_hi;
  logic [RES_W-1:0] rd_data, res_data;
  logic busy, sample, res_valid, started, overrun;
  logic [CH_W-1:0] res_ch;
  logic [NUM_CH-1:0] flags;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  initial begin
    for (int c = 0; c < NUM_CH; c++) begin
      thr_lo[c*RES_W +: RES_W] = 10'd200;
      thr_hi[c*RES_W +: RES_W] = 10'd800;
    end
  end

  adc_xtrig_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CNT_W(CNT_W)) u_adc_xtrig_seq (
    .clk_i(clk), .rst_ni(rst_ni), .xtrig_en_i(xtrig_en),
    .sw_norm_req_i(sw_norm), .sw_norm_ch_i(norm_ch),
    .sw_inj_req_i(sw_inj), .sw_inj_ch_i(inj_ch),
    .xtrig_pulse_i(xtrig), .xtrig_ch_i(xch),
    .samp_cnt_i(samp), .cmp_cnt_i(cmp), .latch_cnt_i(lat),
    .adc_result_i(adc_res), .wdg_en_i(wdg_en), .thr_lo_i(thr_lo), .thr_hi_i(thr_hi),
    .wdg_clr_i(wdg_clr), .rd_ch_i(rd_ch), .rd_data_o(rd_data),
    .busy_o(busy), .sample_o(sample), .res_valid_o(res_valid),
    .res_ch_o(res_ch), .res_data_o(res_data), .wdg_flag_o(flags),
    .xtrig_started_o(started), .overrun_o(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives a one-cycle request; returns at the negedge after the accept edge
  task automatic pulse_req(input bit inj, input bit nrm, input bit trg,
                           input int c_inj, input int c_nrm, input int c_trg);
    @(negedge clk);
    sw_inj = inj; sw_norm = nrm; xtrig = trg;
    inj_ch = CH_W'(c_inj); norm_ch = CH_W'(c_nrm); xch = CH_W'(c_trg);
    @(negedge clk);
    sw_inj = 0; sw_norm = 0; xtrig = 0;
  endtask

  task automatic measure(output int sw, output int lt);
    int k = 0;
    sw = 0;
    while (!res_valid && k < 3000) begin
      if (sample) sw++;
      @(negedge clk);
      k++;
    end
    lt = k;
  endtask

  task automatic wait_valid(output int ch);
    int k = 0;
    while (!res_valid && k < 3000) begin
      @(negedge clk);
      k++;
    end
    ch = int'(res_ch);
  endtask

  task automatic clear_flags(input logic [NUM_CH-1:0] m);
    @(negedge clk);
    wdg_clr = m;
    @(negedge clk);
    wdg_clr = 0;
  endtask

  function automatic int slen(input int s);
    return (s <= 6) ? 2*s - 1 : 2*s - 2;
  endfunction

  function automatic int exp_flag(input int ch, input int r);
    return (wdg_en[ch] && (r < 200 || r > 800)) ? 1 : 0;
  endfunction

  // one software conversion with full result checking
  task automatic sw_conv(input int ch, input int r, input bit inj);
    int sw, lt;
    adc_res = RES_W'(r);
    rd_ch = CH_W'(ch);
    pulse_req(inj, !inj, 0, ch, ch, 0);
    measure(sw, lt);
    chk("R6 sample width", sw, slen(int'(samp)));
    chk("R7 latency", lt, slen(int'(samp)) + 20*int'(cmp) + 2*int'(lat));
    chk("R8 res_ch", int'(res_ch), ch);
    chk("R8 res_data", int'(res_data), r);
    chk("R8 data register", int'(rd_data), r);
    chk("R9 watchdog flag", int'(flags[ch]), exp_flag(ch, r));
    @(negedge clk);
    chk("R8 valid one cycle", int'(res_valid), 0);
  endtask

  initial begin
    #(8*150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int idx = 0;
    int c, sw, lt;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 sample", int'(sample), 0);
    chk("R11 valid", int'(res_valid), 0);
    chk("R11 flags", int'(flags), 0);
    chk("R11 started", int'(started), 0);
    chk("R11 overrun", int'(overrun), 0);
    chk("R11 data reg", int'(rd_data), 0);

    // sweep: sample 3..8, cmp 1..2, latch 1..2
    for (int s = 3; s <= 8; s++)
      for (int m = 1; m <= 2; m++)
        for (int l = 1; l <= 2; l++) begin
          samp = CNT_W'(s); cmp = CNT_W'(m); lat = CNT_W'(l);
          clear_flags('1);
          chk("R10 flags cleared", int'(flags), 0);
          sw_conv(idx % NUM_CH, (idx*137 + 61) % 1024, idx[0]);
          idx++;
        end

    // R9 boundaries on channel 0 (enabled) and channel 1 (disabled)
    samp = 5'd4; cmp = 5'd1; lat = 5'd1;
    clear_flags('1);
    sw_conv(0, 200, 1'b0);
    sw_conv(0, 800, 1'b0);
    sw_conv(1, 5, 1'b0);
    sw_conv(0, 199, 1'b0);
    sw_conv(2, 801, 1'b1);
    // R10 clear only channel 0
    clear_flags(4'b0001);
    chk("R10 cleared bit 0", int'(flags[0]), 0);
    chk("R10 bit 2 kept", int'(flags[2]), 1);

    // R1 injected wins over normal in same cycle
    adc_res = 10'd300;
    pulse_req(1, 1, 0, 3, 1, 0);
    wait_valid(c);
    chk("R1 injected priority", c, 3);
    // R1 request while busy is dropped
    pulse_req(0, 1, 0, 0, 2, 0);
    pulse_req(0, 1, 0, 0, 1, 0);
    wait_valid(c);
    chk("R1 first of busy pair", c, 2);
    repeat (60) @(negedge clk);
    chk("R1 busy request dropped", int'(busy), 0);
    // R1 trigger ignored in normal mode
    pulse_req(0, 0, 1, 0, 0, 2);
    chk("R1 trigger ignored", int'(busy), 0);

    // trigger-control mode
    @(negedge clk);
    xtrig_en = 1;
    pulse_req(1, 1, 0, 1, 1, 0);
    chk("R2 sw dropped busy", int'(busy), 0);
    chk("R2 sw not started", int'(started), 0);
    adc_res = 10'd444;
    pulse_req(0, 0, 1, 0, 0, 3);
    chk("R3 trigger starts", int'(busy), 1);
    chk("R4 started set", int'(started), 1);
    pulse_req(0, 0, 1, 0, 0, 1);
    chk("R5 no overrun yet", int'(overrun), 0);
    pulse_req(0, 0, 1, 0, 0, 2);
    chk("R5 overrun set", int'(overrun), 1);
    wait_valid(c);
    chk("R3 trigger channel", c, 3);
    @(negedge clk);
    measure(sw, lt);
    chk("R5 pending converted", int'(res_ch), 1);
    chk("R5 pending latency", lt, slen(4) + 20 + 2 - 1);
    repeat (60) @(negedge clk);
    chk("R5 overflowed trigger lost", int'(busy), 0);
    chk("R4 started sticky", int'(started), 1);
    chk("R5 overrun sticky", int'(overrun), 1);
    xtrig_en = 0;
    @(negedge clk);
    chk("R4 started cleared", int'(started), 0);
    chk("R5 overrun cleared", int'(overrun), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule